// File: doc/BRIEF.md
# Fixed-Point PI Increment Calculator

This block computes one velocity-form proportional-integral update each time it is asked. The caller raises `arm` and holds it. On the first clock edge that sees `arm` high, the block captures its inputs: a signed setpoint, a signed measured sample, two signed fixed-point gains, the error from the previous update and the previous adjustment. It then forms the current error and runs two radix-2 Booth shift-add multipliers side by side. One multiplier forms integral gain times current error. The other forms proportional gain times previous error.

When both multipliers have finished, the block adds the integral product to the previous adjustment, subtracts the proportional product, and raises `done`. It also narrows the result to a signed code for a 20-bit converter data field. The caller reads the results and drops `arm`, which clears `done`. The outputs keep their values until the next update completes.

Gains are 64-bit signed values with 21 integer bits and 43 fractional bits. The error is an integer, so both products and the adjustment carry 43 fractional bits.

Top module: `pi_step`

## Requirements
- R1: The error is `meas - setpt`, computed at ADC_W+1 = 19 bits as a signed value. It appears on `e_cur` when `done` rises.
- R2: Gains are signed two's complement with 43 fractional bits. Each product is kept at full precision (83 bits), with its LSB weighted 2^-43.
- R3: Both multipliers start on the same capture edge. `done` is raised only when both of them report finished.
- R4: `adj` = `adj_prev` + `ki`·`e_cur` − `kp`·`e_prev`, taken as an 84-bit two's complement value that wraps modulo 2^84.
- R5: `dac_code` is `adj` arithmetically shifted right by 41, which leaves 2 fractional bits. When that value fits, it is passed through as a 20-bit signed integer.
- R6: If the shifted value is above 2^19−1, `dac_code` is 20'h7FFFF.
- R7: If the shifted value is below −2^19, `dac_code` is 20'h80000.
- R8: `done` rises at the 21st consecutive rising edge that samples `arm` high, counting the capture edge as the first. This is one load cycle, 19 multiply steps and one result cycle.
- R9: `done` is low after any edge that samples `arm` low. `adj`, `dac_code` and `e_cur` change only on the edge where `done` rises.
- R10: Input changes after the capture edge do not affect the result of the update in progress.
- R11: After synchronous reset, `done`, `adj`, `dac_code` and `e_cur` are zero.
- R12: Dropping `arm` before `done` abandons the update. The next `arm` starts a fresh capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arm | input | 1 | Request; held high until `done` is seen |
| setpt | input | 18 | Signed setpoint |
| meas | input | 18 | Signed measured sample |
| kp | input | 64 | Proportional gain, signed, 43 fractional bits |
| ki | input | 64 | Integral gain, signed, 43 fractional bits |
| e_prev | input | 19 | Error from the previous update |
| adj_prev | input | 84 | Previous adjustment, 43 fractional bits |
| done | output | 1 | Result valid; held while `arm` stays high |
| e_cur | output | 19 | Current error |
| adj | output | 84 | New adjustment, 43 fractional bits |
| dac_code | output | 20 | Saturated converter code |

## Verification
The assertions check these properties on every cycle:
- `done` never appears unless both multipliers have finished.
- The two multipliers finish in lockstep.
- `done` falls after `arm` is low.
- The outputs stay stable except on the edge where `done` rises.

The arithmetic itself can only be shown by the bench's scenarios. A wide-integer reference compares the error, the wrapped adjustment and the saturated code against the block on every clock. The scenarios cover error sign changes, fractional gains, both saturation limits, input changes during a computation and an abandoned request.

// File: rtl/pi_step.sv
module pi_step #(
  parameter int ADC_W     = 18,
  parameter int GAIN_INT  = 21,
  parameter int GAIN_FRAC = 43,
  parameter int DAC_W     = 20
) (
  input  logic                                           clk,
  input  logic                                           rst,
  input  logic                                           arm,
  input  logic signed [ADC_W-1:0]                        setpt,
  input  logic signed [ADC_W-1:0]                        meas,
  input  logic signed [GAIN_INT+GAIN_FRAC-1:0]           kp,
  input  logic signed [GAIN_INT+GAIN_FRAC-1:0]           ki,
  input  logic signed [ADC_W:0]                          e_prev,
  input  logic signed [GAIN_INT+GAIN_FRAC+ADC_W+1:0]     adj_prev,
  output logic                                           done,
  output logic signed [ADC_W:0]                          e_cur,
  output logic signed [GAIN_INT+GAIN_FRAC+ADC_W+1:0]     adj,
  output logic signed [DAC_W-1:0]                        dac_code
);
  localparam int G_W   = GAIN_INT + GAIN_FRAC;
  localparam int E_W   = ADC_W + 1;
  localparam int P_W   = G_W + E_W;
  localparam int ACC_W = P_W + 1;
  localparam int DROP  = GAIN_FRAC - (DAC_W - ADC_W);
  localparam int RT_W  = ACC_W - DROP;
  localparam int CNT_W = $clog2(E_W);

  logic taken;
  logic signed [E_W-1:0]   err_q;
  logic signed [ACC_W-1:0] adjp_q;
  logic [1:0] fin;
  logic signed [P_W-1:0] prod_i, prod_p;

  wire load = arm && !taken;
  wire signed [E_W-1:0] err_w = {meas[ADC_W-1], meas} - {setpt[ADC_W-1], setpt};

  always_ff @(posedge clk) begin
    if (rst) begin
      taken  <= 1'b0;
      err_q  <= '0;
      adjp_q <= '0;
    end else if (!arm) begin
      taken <= 1'b0;
    end else if (load) begin
      taken  <= 1'b1;
      err_q  <= err_w;
      adjp_q <= adj_prev;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : mul
    logic signed [P_W-1:0] acc;
    logic signed [P_W-1:0] mc;
    logic [E_W-1:0]        mq;
    logic                  qm1;
    logic [CNT_W-1:0]      cnt;
    logic                  busy, fin_r;

    wire signed [G_W-1:0] gain = (g == 0) ? ki : kp;
    wire signed [E_W-1:0] mult = (g == 0) ? err_w : e_prev;

    always_ff @(posedge clk) begin
      if (rst || !arm) begin
        busy  <= 1'b0;
        fin_r <= 1'b0;
        cnt   <= '0;
        if (rst) begin
          acc <= '0;
          mc  <= '0;
          mq  <= '0;
          qm1 <= 1'b0;
        end
      end else if (load) begin
        busy  <= 1'b1;
        fin_r <= 1'b0;
        cnt   <= '0;
        acc   <= '0;
        mc    <= {{(P_W-G_W){gain[G_W-1]}}, gain};
        mq    <= mult;
        qm1   <= 1'b0;
      end else if (busy) begin
        case ({mq[0], qm1})
          2'b01:   acc <= acc + mc;
          2'b10:   acc <= acc - mc;
          default: acc <= acc;
        endcase
        mc  <= mc <<< 1;
        qm1 <= mq[0];
        mq  <= mq >> 1;
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(E_W-1)) begin
          busy  <= 1'b0;
          fin_r <= 1'b1;
        end
      end
    end
    assign fin[g] = fin_r;
  end

  assign prod_i = mul[0].acc;
  assign prod_p = mul[1].acc;

  wire signed [ACC_W-1:0] sum = adjp_q
                              + {{(ACC_W-P_W){prod_i[P_W-1]}}, prod_i}
                              - {{(ACC_W-P_W){prod_p[P_W-1]}}, prod_p};
  wire signed [RT_W-1:0] rt = sum[ACC_W-1:DROP];
  wire [RT_W-DAC_W:0] hi = rt[RT_W-1:DAC_W-1];
  wire fits = (&hi) || !(|hi);
  wire signed [DAC_W-1:0] sat = fits ? rt[DAC_W-1:0]
                              : (rt[RT_W-1] ? {1'b1, {(DAC_W-1){1'b0}}}
                                            : {1'b0, {(DAC_W-1){1'b1}}});

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      adj      <= '0;
      dac_code <= '0;
      e_cur    <= '0;
    end else if (!arm) begin
      done <= 1'b0;
    end else if (fin[0] && fin[1] && !done) begin
      done     <= 1'b1;
      adj      <= sum;
      dac_code <= sat;
      e_cur    <= err_q;
    end
  end

  assert_both_fin_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (fin[0] && fin[1]));
  assert_lockstep_R3: assert property (@(posedge clk) disable iff (rst)
    fin[0] == fin[1]);
  assert_rise_after_fin_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(fin[0] && fin[1] && arm));
  assert_drop_R9: assert property (@(posedge clk) disable iff (rst)
    !arm |=> !done);
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(done && !$past(done)) |-> ($stable(adj) && $stable(dac_code) && $stable(e_cur)));
endmodule

// File: tb/pi_step_tb.sv
module pi_step_tb;
  localparam int ADC_W = 18, E_W = 19, G_W = 64, ACC_W = 84, DAC_W = 20;
  localparam int LAT = 21;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, arm;
  logic signed [ADC_W-1:0] setpt, meas;
  logic signed [G_W-1:0]   kp, ki;
  logic signed [E_W-1:0]   e_prev;
  logic signed [ACC_W-1:0] adj_prev;
  logic done;
  logic signed [E_W-1:0]   e_cur;
  logic signed [ACC_W-1:0] adj;
  logic signed [DAC_W-1:0] dac_code;

  pi_step u_dut (.clk(clk), .rst(rst), .arm(arm), .setpt(setpt), .meas(meas),
    .kp(kp), .ki(ki), .e_prev(e_prev), .adj_prev(adj_prev), .done(done),
    .e_cur(e_cur), .adj(adj), .dac_code(dac_code));

  int total = 0, bad = 0;
  bit finished = 0;

  bit m_taken = 0, m_done = 0;
  int m_cnt = 0;
  logic signed [E_W-1:0]   m_e, p_e;
  logic signed [ACC_W-1:0] m_adj, p_adj;
  logic signed [DAC_W-1:0] m_dac, p_dac;

  localparam logic signed [G_W-1:0] ONE = 64'sd1 <<< 43;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic reference(output logic signed [E_W-1:0] e,
                           output logic signed [ACC_W-1:0] a,
                           output logic signed [DAC_W-1:0] d);
    logic signed [127:0] ww, pi, pp, s, q;
    ww = meas; ww = ww - setpt;
    e = ww[E_W-1:0];
    pi = ki; pi = pi * e;
    pp = kp; pp = pp * e_prev;
    s = adj_prev; s = s + pi - pp;
    a = s[ACC_W-1:0];
    s = a;
    q = s >>> 41;
    if (q > 128'sd524287) d = 20'h7FFFF;
    else if (q < -128'sd524288) d = 20'h80000;
    else d = q[DAC_W-1:0];
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst) begin
      m_taken = 0; m_done = 0; m_cnt = 0; m_e = '0; m_adj = '0; m_dac = '0;
    end else if (!arm) begin
      m_taken = 0; m_done = 0; m_cnt = 0;
    end else if (!m_taken) begin
      m_taken = 1; m_cnt = 1;
      reference(p_e, p_adj, p_dac);
    end else if (m_cnt > 0 && m_cnt < LAT) begin
      m_cnt++;
      if (m_cnt == LAT) begin
        m_done = 1; m_e = p_e; m_adj = p_adj; m_dac = p_dac;
      end
    end
    #1;
    check(done == m_done, "R8", "done", done, m_done);
    check(e_cur == m_e, "R1", "e_cur", e_cur, m_e);
    check(adj == m_adj, "R4", "adj", adj, m_adj);
    check(dac_code == m_dac, "R5", "dac_code", dac_code, m_dac);
  endtask

  task automatic run(input logic signed [ADC_W-1:0] sp, input logic signed [ADC_W-1:0] ms,
                     input logic signed [G_W-1:0] p, input logic signed [G_W-1:0] i,
                     input logic signed [E_W-1:0] ep, input logic signed [ACC_W-1:0] ap);
    setpt = sp; meas = ms; kp = p; ki = i; e_prev = ep; adj_prev = ap;
    arm = 1'b1;
    for (int k = 0; k < LAT + 2; k++) tick();
    arm = 1'b0;
    tick();
    check(done == 1'b0, "R9", "done after drop", done, 0);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1; arm = 0; setpt = '0; meas = '0; kp = '0; ki = '0; e_prev = '0; adj_prev = '0;
    tick(); tick();
    rst = 0;
    tick();
    check(done == 0 && adj == 0 && dac_code == 0 && e_cur == 0, "R11", "reset state",
          {done, dac_code}, 0);

    run(18'sd100, 18'sd150, ONE, ONE, 19'sd10, '0);
    check(e_cur == 19'sd50, "R1", "error value", e_cur, 50);
    check(dac_code == 20'sd160, "R5", "dac code", dac_code, 160);

    run(18'sd150, 18'sd100, ONE, ONE, 19'sd50, '0);
    check(e_cur == -19'sd50, "R1", "negative error", e_cur, -50);

    run(18'sd0, 18'sd3, ONE >>> 2, ONE >>> 1, -19'sd7, 84'sd5);
    check(adj == (84'sd5 + (84'sd3 * (ONE >>> 1)) + (84'sd7 * (ONE >>> 2))), "R2",
          "fractional gains", adj, 0);

    run(-18'sd131072, 18'sd131071, -(ONE), 64'sd1 <<< 55, -19'sd262144, '0);
    check(dac_code == 20'h7FFFF, "R6", "positive saturation", dac_code, 20'h7FFFF);

    run(18'sd131071, -18'sd131072, 64'sd1 <<< 55, 64'sd1 <<< 55, 19'sd100, '0);
    check(dac_code == 20'h80000, "R7", "negative saturation", dac_code, 20'h80000);

    run(18'sd0, 18'sd1, 64'sh7FFF_FFFF_FFFF_FFFF, 64'sh8000_0000_0000_0000,
        19'sd262143, {1'b0, {83{1'b1}}});

    setpt = 18'sd10; meas = 18'sd30; kp = '0; ki = ONE; e_prev = '0; adj_prev = '0;
    arm = 1'b1;
    tick();
    setpt = 18'sd999; meas = -18'sd999; ki = -(ONE); adj_prev = 84'sd12345;
    for (int k = 0; k < LAT + 1; k++) tick();
    check(e_cur == 19'sd20 && dac_code == 20'sd80, "R10", "captured inputs", dac_code, 80);
    arm = 1'b0; tick();

    setpt = 18'sd0; meas = 18'sd9; ki = ONE; kp = '0; adj_prev = '0;
    arm = 1'b1;
    for (int k = 0; k < 8; k++) tick();
    arm = 1'b0; tick();
    check(done == 0 && dac_code == 20'sd80, "R12", "abandoned update", dac_code, 80);
    meas = 18'sd4;
    arm = 1'b1;
    for (int k = 0; k < LAT - 1; k++) tick();
    check(done == 0, "R8", "not done before latency", done, 0);
    tick();
    check(done == 1 && dac_code == 20'sd16, "R3", "fresh capture result", dac_code, 16);
    arm = 1'b0; tick();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule